// File: doc/BRIEF.md
# Memory-mapped interrupt controller

This block gathers a parameterised set of interrupt lines, up to 32, and folds them into one request line for a processor. Each line is fixed at build time as either edge-sensitive or level-sensitive. Events are captured in a status register, gated by a per-source enable register, and combined with two global enable bits into the request output. Software drives the block over a plain 32-bit register bus. The bus has a byte address, a write strobe with write data, and a read strobe. Read data is returned combinationally in the same cycle.

A typical service routine reads the vector register to find the source to handle, and acknowledges that source by writing a one-hot mask. It then reads the vector again until it returns all-ones. Individual sources are enabled or disabled through dedicated set and clear registers, so no read-modify-write is needed.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, the status, pending, enable and master registers read 0, the vector register reads 0xFFFFFFFF and `irq_out` is low.
- R2: The master register at offset 0x1C holds two bits that read back exactly as written. Bit 0 is the global enable and bit 1 is the request-output enable. All other bits read as 0.
- R3: A write to offset 0x10 ORs the written mask into the enable register. A write to offset 0x14 clears the enable bits set in the mask. All other enable bits keep their value. A write to offset 0x08 replaces the whole enable register.
- R4: A write to offset 0x0C clears every status bit whose mask bit is 1. Writing 0xFFFFFFFF clears every latched edge event.
- R5: Offset 0x18 returns the lowest index whose pending bit is set, or 0xFFFFFFFF when no bit is pending.
- R6: A source whose bit in `EDGE_MASK` is 1 sets its status bit on a rising input, one clock edge later. The bit stays set until it is acknowledged. A rising input in the same cycle as its acknowledge leaves the bit set.
- R7: A source whose bit in `EDGE_MASK` is 0 sets its status bit on every clock edge at which its input is high. An acknowledge while the input is still high therefore leaves the bit set.
- R8: Status and enable bits at index `NUM_SRC` and above do not exist and read as 0, including after writing 0xFFFFFFFF.
- R9: The pending register at offset 0x04 reads as status AND enable. Writing 0 to the enable register clears every pending bit.
- R10: Writes to the status (0x00), pending (0x04) and vector (0x18) offsets change no register.
- R11: `irq_out` is high exactly when both master bits are 1 and at least one pending bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the register; bits 1:0 ignored |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high, else 0 |
| irq_in | input | NUM_SRC | Interrupt source lines |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the controller with `NUM_SRC` = 6 and `EDGE_MASK` = 0x15, so sources 0, 2 and 4 are edge-sensitive and sources 1, 3 and 5 are level-sensitive. The small count puts the non-existent upper bits within reach of all-ones writes. The mixed mask lets one run exercise both acknowledge behaviours and a priority chain that passes from edge sources to a level source. Scenarios include acknowledging a held edge input, acknowledging a still-high level input, a new edge that coincides with its acknowledge, and gating of the request output by each master bit.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int SEL_W  = 3;

  // word select = byte offset / 4
  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS = 3'd0,
    SEL_PEND   = 3'd1,
    SEL_ENABLE = 3'd2,
    SEL_ACK    = 3'd3,
    SEL_SETEN  = 3'd4,
    SEL_CLREN  = 3'd5,
    SEL_VECTOR = 3'd6,
    SEL_MASTER = 3'd7
  } reg_sel_e;

  localparam logic [DATA_W-1:0] NO_VECTOR = '1;
endpackage

// File: rtl/irqc_capture.sv
`timescale 1ns/1ps
module irqc_capture #(
  parameter int          NUM_SRC   = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] ack_mask,
  output logic [NUM_SRC-1:0] status
);
  logic [NUM_SRC-1:0] status_d;
  logic [NUM_SRC-1:0] status_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q;
      logic rise;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= irq_in[i];
      end

      assign rise        = irq_in[i] & ~prev_q;
      // a new edge wins over an acknowledge in the same cycle
      assign status_d[i] = rise | (status_q[i] & ~ack_mask[i]);

      assert_edge_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_in[i]) |=> status_q[i]);
    end else begin : g_level
      assign status_d[i] = irq_in[i] | (status_q[i] & ~ack_mask[i]);

      assert_level_reassert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_in[i] |=> status_q[i]);
    end

    assert_status_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[i] && !ack_mask[i]) |=> status_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status = status_q;
endmodule

// File: rtl/irqc_vector.sv
`timescale 1ns/1ps
module irqc_vector #(
  parameter int NUM_SRC = 32,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] pending,
  output logic               hit,
  output logic [IDX_W-1:0]   index
);
  // lowest-numbered pending source has top priority
  always_comb begin
    index = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i]) index = IDX_W'(i);
    end
  end

  assign hit = |pending;
endmodule

// File: rtl/irq_ctrl.sv
`timescale 1ns/1ps
module irq_ctrl #(
  parameter int          NUM_SRC   = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [irqc_pkg::ADDR_W-1:0]  bus_addr,
  input  logic                         bus_wr,
  input  logic [irqc_pkg::DATA_W-1:0]  bus_wdata,
  input  logic                         bus_rd,
  output logic [irqc_pkg::DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0]           irq_in,
  output logic                         irq_out
);
  import irqc_pkg::*;

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  reg_sel_e           sel;
  logic               unused_addr_lsb;
  logic [NUM_SRC-1:0] wmask;
  logic [NUM_SRC-1:0] en_d, en_q;
  logic               en_we;
  logic [1:0]         mer_q;
  logic               mer_we;
  logic [NUM_SRC-1:0] ack_mask;
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] pending;
  logic               vec_hit;
  logic [IDX_W-1:0]   vec_idx;
  logic [DATA_W-1:0]  vec_word;

  assign sel             = reg_sel_e'(bus_addr[ADDR_W-1:2]);
  assign unused_addr_lsb = ^bus_addr[1:0];
  assign wmask           = bus_wdata[NUM_SRC-1:0];

  // enable register: next state
  always_comb begin
    en_d  = en_q;
    en_we = 1'b0;
    if (bus_wr) begin
      case (sel)
        SEL_ENABLE: begin en_d = wmask;          en_we = 1'b1; end
        SEL_SETEN:  begin en_d = en_q | wmask;   en_we = 1'b1; end
        SEL_CLREN:  begin en_d = en_q & ~wmask;  en_we = 1'b1; end
        default:    begin en_d = en_q;           en_we = 1'b0; end
      endcase
    end
  end

  assign mer_we   = bus_wr && (sel == SEL_MASTER);
  assign ack_mask = (bus_wr && (sel == SEL_ACK)) ? wmask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      mer_q <= '0;
    end else begin
      if (en_we)  en_q  <= en_d;
      if (mer_we) mer_q <= bus_wdata[1:0];
    end
  end

  irqc_capture #(
    .NUM_SRC   (NUM_SRC),
    .EDGE_MASK (EDGE_MASK)
  ) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .ack_mask (ack_mask),
    .status   (status)
  );

  assign pending = status & en_q;

  irqc_vector #(
    .NUM_SRC (NUM_SRC)
  ) u_vector (
    .pending (pending),
    .hit     (vec_hit),
    .index   (vec_idx)
  );

  assign vec_word = vec_hit ? DATA_W'(vec_idx) : NO_VECTOR;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (sel)
        SEL_STATUS: bus_rdata = DATA_W'(status);
        SEL_PEND:   bus_rdata = DATA_W'(pending);
        SEL_ENABLE: bus_rdata = DATA_W'(en_q);
        SEL_VECTOR: bus_rdata = vec_word;
        SEL_MASTER: bus_rdata = DATA_W'(mer_q);
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign irq_out = mer_q[0] & mer_q[1] & vec_hit;

  // ---------------- assertions ----------------
  assert_set_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_SETEN) |=> ((en_q & $past(wmask)) == $past(wmask)));

  assert_clear_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_CLREN) |=> ((en_q & $past(wmask)) == '0));

  assert_enable_untouched_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (sel == SEL_ENABLE || sel == SEL_SETEN || sel == SEL_CLREN)) |=> $stable(en_q));

  assert_master_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mer_we |=> (mer_q == $past(bus_wdata[1:0])));

  assert_vector_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |-> !vec_hit);

  assert_vector_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_hit |-> (pending[vec_idx] && ((pending & ((NUM_SRC'(1) << vec_idx) - NUM_SRC'(1))) == '0)));

  assert_request_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((status & en_q) != '0));
endmodule

// File: tb/test_irq_ctrl.sv
`timescale 1ns/1ps
module test_irq_ctrl;
  localparam int          NSRC  = 6;
  localparam logic [31:0] EMASK = 32'h0000_0015;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic [NSRC-1:0] irq_in;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  irq_ctrl #(.NUM_SRC(NSRC), .EDGE_MASK(EMASK)) i_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  // monitor: compares read data mid-cycle against the scoreboard queue
  always @(negedge clk) begin
    if (bus_rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #2;
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #2;
    bus_rd = 1'b0;
  endtask

  task automatic set_in(input logic [NSRC-1:0] v);
    @(posedge clk); #2;
    irq_in = v;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_out !== e) begin
      errors++;
      $display("FAIL %s: irq_out actual %b expected %b", t, irq_out, e);
    end
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    bus_rd = 1'b0; irq_in = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    rd(5'h00, 32'h0, "R1 status");
    rd(5'h04, 32'h0, "R1 pending");
    rd(5'h08, 32'h0, "R1 enable");
    rd(5'h1C, 32'h0, "R1 master");
    rd(5'h18, 32'hFFFF_FFFF, "R1 vector");
    chk_irq(1'b0, "R1 irq_out");

    // R2 master readback
    wr(5'h1C, 32'hFFFF_FFFF);
    rd(5'h1C, 32'h3, "R2 master all-ones");
    wr(5'h1C, 32'h2);
    rd(5'h1C, 32'h2, "R2 master bit1");
    wr(5'h1C, 32'h3);

    // R8 upper bits, R9 zero enable
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, 32'h3F, "R8 enable width");
    wr(5'h08, 32'h0);
    rd(5'h08, 32'h0, "R9 enable cleared");

    // R3 set / clear enable
    wr(5'h10, 32'h05);
    rd(5'h08, 32'h05, "R3 set 05");
    wr(5'h10, 32'h02);
    rd(5'h08, 32'h07, "R3 set 02");
    wr(5'h14, 32'h04);
    rd(5'h08, 32'h03, "R3 clear 04");

    // R6 edge source 0
    set_in(6'h01);
    tick(1);
    rd(5'h00, 32'h01, "R6 edge latched");
    rd(5'h04, 32'h01, "R9 pending");
    rd(5'h18, 32'h0, "R5 vector 0");
    chk_irq(1'b1, "R11 irq high");
    wr(5'h0C, 32'h01);
    tick(1);
    rd(5'h00, 32'h0, "R4 ack edge held high");
    chk_irq(1'b0, "R11 irq low after ack");

    // R7 level source 1
    set_in(6'h02);
    tick(1);
    rd(5'h00, 32'h02, "R7 level latched");
    rd(5'h18, 32'h1, "R5 vector 1");
    wr(5'h0C, 32'h02);
    rd(5'h00, 32'h02, "R7 ack while high");
    set_in(6'h00);
    tick(1);
    wr(5'h0C, 32'h02);
    rd(5'h00, 32'h0, "R7 ack after low");

    // R6 edge coinciding with its acknowledge
    set_in(6'h04);
    tick(1);
    rd(5'h00, 32'h04, "R6 edge 2 latched");
    set_in(6'h00);
    tick(1);
    @(posedge clk); #2;
    irq_in = 6'h04; bus_addr = 5'h0C; bus_wdata = 32'h04; bus_wr = 1'b1;
    @(posedge clk); #2;
    bus_wr = 1'b0;
    rd(5'h00, 32'h04, "R6 edge beats ack");
    wr(5'h0C, 32'h3F);
    rd(5'h00, 32'h0, "R4 ack no new edge");

    // R5 priority chain
    wr(5'h08, 32'h3F);
    set_in(6'h00);
    tick(1);
    set_in(6'h34);
    tick(1);
    rd(5'h00, 32'h34, "R6 multi latch");
    rd(5'h18, 32'h2, "R5 lowest 2");
    wr(5'h0C, 32'h04);
    rd(5'h18, 32'h4, "R5 next 4");
    wr(5'h0C, 32'h10);
    rd(5'h18, 32'h5, "R5 level 5");
    wr(5'h14, 32'h20);
    rd(5'h04, 32'h0, "R9 masked pending");
    rd(5'h18, 32'hFFFF_FFFF, "R5 none pending");
    rd(5'h00, 32'h20, "R9 status unmasked");
    chk_irq(1'b0, "R11 masked source");

    // R11 master gating
    wr(5'h10, 32'h20);
    chk_irq(1'b1, "R11 both master bits");
    wr(5'h1C, 32'h1);
    chk_irq(1'b0, "R11 only bit0");
    wr(5'h1C, 32'h2);
    chk_irq(1'b0, "R11 only bit1");
    wr(5'h1C, 32'h3);
    chk_irq(1'b1, "R11 restored");
    wr(5'h08, 32'h0);
    chk_irq(1'b0, "R9 enable zero masks");
    rd(5'h04, 32'h0, "R9 pending zero");

    // R10 writes to read-only offsets
    set_in(6'h00);
    tick(1);
    set_in(6'h05);
    tick(1);
    wr(5'h00, 32'h0);
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h18, 32'h0);
    rd(5'h00, 32'h25, "R10 status unchanged");
    rd(5'h08, 32'h0, "R10 enable unchanged");
    rd(5'h1C, 32'h3, "R10 master unchanged");

    // R4 all-ones acknowledge
    set_in(6'h00);
    tick(1);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h00, 32'h0, "R4 ack all");
    rd(5'h00, 32'h0, "R8 no upper status");

    tick(2);
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule